// File: doc/BRIEF.md
# PLD Output Macrocell Slice

This block is one output slice of a small sum-of-products programmable logic device. A configuration-driven AND plane builds product terms from the true and complemented forms of the external array inputs and of the slice's own feedback signal. A fixed OR gate sums a parameterised number of these terms, and an output macrocell conditions the sum before it reaches the pin.

The configuration vector is loaded before use and held steady while the slice runs. It selects one of three operating modes. In dedicated-input mode the output driver is off. In combinatorial mode the sum drives the pin directly. In registered mode a flip-flop captures the sum and feeds its own state back into the array. A polarity bit can invert what reaches the pin. Two further product terms, held in the same vector, control the flip-flop: one clears it at once without waiting for a clock, and the other forces it to 1 at the next clock edge.

The pad is modelled as a separate input (`pin_in`), so the pad value and the slice's drive are distinct ports. A global active-low reset clears the register immediately. Its release is synchronised to the clock.

Top module: `pld_output_slice`

## Requirements
- R1: With NCOL = N_IN + 1 array columns, column k < N_IN is `in_bits[k]` and column N_IN is `fb`. Product term j owns `cfg[j*2*NCOL +: 2*NCOL]`. In that field, bit 2k connects the true literal of column k and bit 2k+1 connects its complement. The term is the AND of its connected literals.
- R2: A product term with both literals of one column connected is 0. A term with no connection at all is also 0.
- R3: The sum is the OR of product terms 0 to N_PT-1. Term N_PT is the clear term and term N_PT+1 is the preset term; neither is part of the sum.
- R4: The mode field `cfg[MODE_LSB +: 2]` (MODE_LSB = (N_PT+2)*2*NCOL) selects the mode. 2'b00 and 2'b11 select dedicated input, with `pin_oe` = 0 and `pin_out` = 0. 2'b01 selects combinatorial and 2'b10 selects registered; both drive `pin_oe` = 1.
- R5: The polarity bit `cfg[MODE_LSB+2]` inverts the pin value when it is 1. In combinatorial mode `pin_out` = sum XOR polarity. In registered mode `pin_out` = register XOR polarity.
- R6: At each rising clock edge the register captures the sum. In registered mode `fb` equals the register state before any polarity inversion.
- R7: In combinatorial and dedicated-input modes `fb` equals `pin_in`, and the array sees that value in column N_IN.
- R8: When the preset term is 1 at a rising edge, the register becomes 1 at that edge and not before.
- R9: While the clear term is 1 the register is 0 at once, with no clock edge needed. The clear term wins over the preset term.
- R10: While `rst_n` is low the register is 0 at once. After `rst_n` rises, the register first captures at the third rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the register and the reset release |
| rst_n | input | 1 | Global reset, active low, asserted asynchronously |
| cfg | input | CFG_W | Configuration vector: product-term connections, mode, polarity |
| in_bits | input | N_IN | External array inputs |
| pin_in | input | 1 | Value present on the pad |
| pin_out | output | 1 | Value the slice drives onto the pad |
| pin_oe | output | 1 | Output driver enable |
| fb | output | 1 | Feedback signal that the array sees in column N_IN |

## Verification
The assertions take the configuration to be static between clock edges. They also take the clear and preset terms to be free of the feedback column, so the asynchronous clear cannot re-trigger itself through the register it clears. The checks assume that array inputs and `pin_in` do not move at a rising edge. The stimulus changes every input only at falling edges and waits before sampling. It keeps the feedback literal out of the control terms. In combinatorial mode it drives the pad independently, so no combinational loop forms through the pin.

// File: rtl/pld_slice_pkg.sv
package pld_slice_pkg;

  typedef enum logic [1:0] {
    OMC_INPUT = 2'b00,
    OMC_COMB  = 2'b01,
    OMC_REG   = 2'b10,
    OMC_SPARE = 2'b11
  } omc_mode_e;

endpackage

// File: rtl/pld_reset_sync.sv
module pld_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/pld_product_term.sv
module pld_product_term #(
  parameter int NCOL = 5
) (
  input  logic [2*NCOL-1:0] conn,
  input  logic [NCOL-1:0]   col,
  output logic              term
);

  logic any_conn;
  logic all_true;

  always_comb begin
    any_conn = |conn;
    all_true = 1'b1;
    for (int k = 0; k < NCOL; k++) begin
      if (conn[2*k] && !col[k]) begin
        all_true = 1'b0;
      end
      if (conn[2*k+1] && col[k]) begin
        all_true = 1'b0;
      end
    end
    term = any_conn & all_true;
  end

endmodule

// File: rtl/pld_and_or_array.sv
module pld_and_or_array #(
  parameter int N_IN = 4,
  parameter int N_PT = 8,
  localparam int NCOL   = N_IN + 1,
  localparam int TERM_W = 2 * NCOL,
  localparam int N_ALL  = N_PT + 2,
  localparam int PLANE_W = N_ALL * TERM_W
) (
  input  logic [PLANE_W-1:0] plane_cfg,
  input  logic [NCOL-1:0]    col,
  output logic               sum,
  output logic               clr_term,
  output logic               pre_term
);

  logic [N_ALL-1:0] pt;

  for (genvar j = 0; j < N_ALL; j++) begin : g_term
    pld_product_term #(
      .NCOL(NCOL)
    ) u_term (
      .conn(plane_cfg[j*TERM_W +: TERM_W]),
      .col (col),
      .term(pt[j])
    );
  end

  assign sum      = |pt[N_PT-1:0];
  assign clr_term = pt[N_PT];
  assign pre_term = pt[N_PT+1];

endmodule

// File: rtl/pld_macrocell.sv
module pld_macrocell
  import pld_slice_pkg::*;
(
  input  logic      clk,
  input  logic      rst_sync_n,
  input  omc_mode_e mode,
  input  logic      pol_inv,
  input  logic      sum,
  input  logic      clr_term,
  input  logic      pre_term,
  input  logic      pin_in,
  output logic      pin_out,
  output logic      pin_oe,
  output logic      fb,
  output logic      reg_q
);

  logic d_nxt;
  logic clr_any;

  // Next state: the preset term forces a 1, otherwise the sum is loaded.
  always_comb begin
    d_nxt = pre_term ? 1'b1 : sum;
  end

  assign clr_any = clr_term | ~rst_sync_n;

  always_ff @(posedge clk or posedge clr_any) begin
    if (clr_any) begin
      reg_q <= 1'b0;
    end else begin
      reg_q <= d_nxt;
    end
  end

  always_comb begin
    case (mode)
      OMC_COMB: begin
        pin_oe  = 1'b1;
        pin_out = sum ^ pol_inv;
        fb      = pin_in;
      end
      OMC_REG: begin
        pin_oe  = 1'b1;
        pin_out = reg_q ^ pol_inv;
        fb      = reg_q;
      end
      default: begin
        pin_oe  = 1'b0;
        pin_out = 1'b0;
        fb      = pin_in;
      end
    endcase
  end

endmodule

// File: rtl/pld_output_slice.sv
module pld_output_slice
  import pld_slice_pkg::*;
#(
  parameter int N_IN = 4,
  parameter int N_PT = 8,
  localparam int NCOL     = N_IN + 1,
  localparam int PLANE_W  = (N_PT + 2) * 2 * NCOL,
  localparam int MODE_LSB = PLANE_W,
  localparam int POL_BIT  = PLANE_W + 2,
  localparam int CFG_W    = PLANE_W + 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg,
  input  logic [N_IN-1:0]  in_bits,
  input  logic             pin_in,
  output logic             pin_out,
  output logic             pin_oe,
  output logic             fb
);

  logic            rst_sync_n;
  logic            sum;
  logic            clr_term;
  logic            pre_term;
  logic            reg_q;
  logic            pol_inv;
  omc_mode_e       mode;
  logic [NCOL-1:0] col;

  assign mode    = omc_mode_e'(cfg[MODE_LSB +: 2]);
  assign pol_inv = cfg[POL_BIT];
  assign col     = {fb, in_bits};

  pld_reset_sync u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  pld_and_or_array #(
    .N_IN(N_IN),
    .N_PT(N_PT)
  ) u_array (
    .plane_cfg(cfg[PLANE_W-1:0]),
    .col      (col),
    .sum      (sum),
    .clr_term (clr_term),
    .pre_term (pre_term)
  );

  pld_macrocell u_mc (
    .clk       (clk),
    .rst_sync_n(rst_sync_n),
    .mode      (mode),
    .pol_inv   (pol_inv),
    .sum       (sum),
    .clr_term  (clr_term),
    .pre_term  (pre_term),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .fb        (fb),
    .reg_q     (reg_q)
  );

endmodule

// File: rtl/pld_output_slice_chk.sv
module pld_output_slice_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rst_sync_n,
  input logic [1:0] mode,
  input logic       pol_inv,
  input logic       sum,
  input logic       clr_term,
  input logic       pre_term,
  input logic       reg_q,
  input logic       pin_in,
  input logic       pin_out,
  input logic       pin_oe,
  input logic       fb
);

  p_input_quiet_r4: assert property (@(negedge clk) disable iff (!rst_n)
    (mode == 2'b00 || mode == 2'b11) |-> (!pin_oe && !pin_out));

  p_driver_on_r4: assert property (@(negedge clk) disable iff (!rst_n)
    (mode == 2'b01 || mode == 2'b10) |-> pin_oe);

  p_comb_polarity_r5: assert property (@(negedge clk) disable iff (!rst_n)
    (mode == 2'b01) |-> (pin_out == (sum ^ pol_inv)));

  p_reg_feedback_r6: assert property (@(negedge clk) disable iff (!rst_n)
    (mode == 2'b10) |-> ((fb ^ pol_inv) == pin_out));

  p_capture_r6: assert property (@(posedge clk) disable iff (!rst_n || clr_term)
    (rst_sync_n && !pre_term) |=> (reg_q == $past(sum)));

  p_pad_feedback_r7: assert property (@(negedge clk) disable iff (!rst_n)
    (mode != 2'b10) |-> (fb == pin_in));

  p_preset_r8: assert property (@(posedge clk) disable iff (!rst_n || clr_term)
    (rst_sync_n && pre_term) |=> reg_q);

  p_clear_now_r9: assert property (@(negedge clk) disable iff (!rst_n)
    clr_term |-> !reg_q);

  p_reset_hold_r10: assert property (@(negedge clk)
    (!rst_n || !rst_sync_n) |-> !reg_q);

endmodule

bind pld_output_slice pld_output_slice_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rst_sync_n(rst_sync_n),
  .mode      (cfg[MODE_LSB +: 2]),
  .pol_inv   (pol_inv),
  .sum       (sum),
  .clr_term  (clr_term),
  .pre_term  (pre_term),
  .reg_q     (reg_q),
  .pin_in    (pin_in),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .fb        (fb)
);

// File: tb/pld_output_slice_bench.sv
`timescale 1ns/1ps
module pld_output_slice_bench;

  localparam int N_IN     = 4;
  localparam int N_PT     = 8;
  localparam int NCOL     = N_IN + 1;
  localparam int TERM_W   = 2 * NCOL;
  localparam int MODE_LSB = (N_PT + 2) * TERM_W;
  localparam int POL_BIT  = MODE_LSB + 2;
  localparam int CFG_W    = MODE_LSB + 3;
  localparam int CLR_T    = N_PT;
  localparam int PRE_T    = N_PT + 1;
  localparam int FB_COL   = N_IN;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [CFG_W-1:0] cfg;
  logic [N_IN-1:0]  in_bits;
  logic             pin_in;
  logic             pin_out;
  logic             pin_oe;
  logic             fb;

  int nchk  = 0;
  int nfail = 0;

  always #2.5 clk = ~clk;

  pld_output_slice #(.N_IN(N_IN), .N_PT(N_PT)) u_pld_output_slice (
    .clk    (clk),
    .rst_n  (rst_n),
    .cfg    (cfg),
    .in_bits(in_bits),
    .pin_in (pin_in),
    .pin_out(pin_out),
    .pin_oe (pin_oe),
    .fb     (fb)
  );

  function automatic logic [CFG_W-1:0] add_lit(input logic [CFG_W-1:0] c,
                                               input int term, input int colx, input bit neg);
    c[term*TERM_W + 2*colx + (neg ? 1 : 0)] = 1'b1;
    return c;
  endfunction

  function automatic logic [CFG_W-1:0] set_mode(input logic [CFG_W-1:0] c,
                                                input logic [1:0] m, input bit p);
    c[MODE_LSB +: 2] = m;
    c[POL_BIT]       = p;
    return c;
  endfunction

  task automatic chk(input string req, input logic act, input logic expv);
    nchk++;
    if (act !== expv) begin
      nfail++;
      $display("FAIL %s: got %b expected %b", req, act, expv);
    end
  endtask

  task automatic edge_then_settle();
    @(posedge clk);
    #1;
  endtask

  // R10: power-up reset, synchronous release, input-mode state under reset
  task automatic t_power_up();
    logic [CFG_W-1:0] c;
    #1;
    chk("R4 reset oe", pin_oe, 1'b0);
    chk("R4 reset out", pin_out, 1'b0);
    c = add_lit('0, 0, 0, 1'b0);
    c = set_mode(c, 2'b10, 1'b0);
    @(negedge clk);
    cfg = c;
    in_bits = 4'b0001;
    #1;
    chk("R10 held in reset", fb, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    edge_then_settle();
    chk("R10 release edge 1", fb, 1'b0);
    edge_then_settle();
    chk("R10 release edge 2", fb, 1'b0);
    edge_then_settle();
    chk("R10 release edge 3", fb, 1'b1);
    chk("R6 pin after capture", pin_out, 1'b1);
  endtask

  // R1 R3 R5: two-term equation over all inputs, both polarities
  task automatic t_comb();
    logic [CFG_W-1:0] c;
    logic expv;
    c = add_lit('0, 0, 0, 1'b0);
    c = add_lit(c, 0, 1, 1'b1);
    c = add_lit(c, 3, 2, 1'b0);
    c = add_lit(c, 3, 3, 1'b0);
    for (int p = 0; p < 2; p++) begin
      for (int v = 0; v < 16; v++) begin
        @(negedge clk);
        cfg = set_mode(c, 2'b01, p[0]);
        in_bits = v[3:0];
        #1;
        expv = ((v[0] & ~v[1]) | (v[2] & v[3])) ^ p[0];
        chk("R1 R3 R5 comb sum", pin_out, expv);
        chk("R4 comb oe", pin_oe, 1'b1);
      end
    end
  endtask

  // R2: contradictory and empty terms never fire
  task automatic t_degenerate();
    logic [CFG_W-1:0] c;
    c = add_lit('0, 0, 0, 1'b0);
    c = add_lit(c, 0, 0, 1'b1);
    c = add_lit(c, 2, 1, 1'b0);
    c = add_lit(c, 2, 1, 1'b1);
    c = add_lit(c, 2, 2, 1'b0);
    for (int p = 0; p < 2; p++) begin
      for (int v = 0; v < 16; v++) begin
        @(negedge clk);
        cfg = set_mode(c, 2'b01, p[0]);
        in_bits = v[3:0];
        #1;
        chk("R2 degenerate terms", pin_out, p[0]);
      end
    end
  endtask

  // R7: pad value reaches the array in combinatorial mode
  task automatic t_comb_feedback();
    logic [CFG_W-1:0] c;
    c = add_lit('0, 0, FB_COL, 1'b0);
    c = add_lit(c, 0, 1, 1'b1);
    c = set_mode(c, 2'b01, 1'b0);
    for (int v = 0; v < 4; v++) begin
      @(negedge clk);
      cfg = c;
      pin_in = v[0];
      in_bits = {2'b00, v[1], 1'b0};
      #1;
      chk("R7 comb fb", fb, v[0]);
      chk("R7 pad into array", pin_out, v[0] & ~v[1]);
    end
  endtask

  // R4 R7: both input-mode codes keep the driver off
  task automatic t_input();
    logic [CFG_W-1:0] c;
    c = add_lit('0, 0, 0, 1'b0);
    for (int m = 0; m < 2; m++) begin
      for (int pv = 0; pv < 2; pv++) begin
        @(negedge clk);
        cfg = set_mode(c, (m == 0) ? 2'b00 : 2'b11, 1'b1);
        in_bits = 4'b1111;
        pin_in = pv[0];
        #1;
        chk("R4 input oe", pin_oe, 1'b0);
        chk("R4 input out", pin_out, 1'b0);
        chk("R7 input fb", fb, pv[0]);
      end
    end
  endtask

  // R6 R5: toggle register built from its own feedback
  task automatic t_registered();
    logic [CFG_W-1:0] c;
    logic expq;
    logic [6:0] seq;
    seq = 7'b1001011;
    c = add_lit('0, 0, 0, 1'b0);
    c = add_lit(c, 0, FB_COL, 1'b1);
    c = add_lit(c, 1, 0, 1'b1);
    c = add_lit(c, 1, FB_COL, 1'b0);
    c = add_lit(c, CLR_T, 3, 1'b0);
    for (int p = 0; p < 2; p++) begin
      @(negedge clk);
      cfg = set_mode(c, 2'b10, p[0]);
      in_bits = 4'b1000;
      #1;
      chk("R9 clear before toggle", fb, 1'b0);
      @(negedge clk);
      in_bits = 4'b0000;
      expq = 1'b0;
      for (int i = 0; i < 7; i++) begin
        @(negedge clk);
        in_bits = {3'b000, seq[i]};
        #1;
        chk("R6 no change before edge", fb, expq);
        edge_then_settle();
        expq = expq ^ seq[i];
        chk("R6 toggle fb", fb, expq);
        chk("R5 reg polarity", pin_out, expq ^ p[0]);
      end
    end
  endtask

  // R8 R9: synchronous preset, immediate clear, clear wins
  task automatic t_preset_clear();
    logic [CFG_W-1:0] c;
    c = add_lit('0, CLR_T, 2, 1'b0);
    c = add_lit(c, PRE_T, 3, 1'b0);
    c = set_mode(c, 2'b10, 1'b0);
    @(negedge clk);
    cfg = c;
    in_bits = 4'b0000;
    edge_then_settle();
    chk("R8 idle zero", fb, 1'b0);
    @(negedge clk);
    in_bits = 4'b1000;
    #1;
    chk("R8 preset waits for edge", fb, 1'b0);
    edge_then_settle();
    chk("R8 preset at edge", fb, 1'b1);
    edge_then_settle();
    chk("R8 preset holds", fb, 1'b1);
    @(negedge clk);
    in_bits = 4'b1100;
    #1;
    chk("R9 clear immediate", fb, 1'b0);
    edge_then_settle();
    chk("R9 clear beats preset", fb, 1'b0);
    @(negedge clk);
    in_bits = 4'b1000;
    edge_then_settle();
    chk("R8 preset after clear", fb, 1'b1);
    @(negedge clk);
    in_bits = 4'b0000;
    edge_then_settle();
    chk("R6 sum zero loads", fb, 1'b0);
  endtask

  // R10: mid-run global reset
  task automatic t_reset_midrun();
    logic [CFG_W-1:0] c;
    c = add_lit('0, 0, 0, 1'b0);
    c = set_mode(c, 2'b10, 1'b0);
    @(negedge clk);
    cfg = c;
    in_bits = 4'b0001;
    edge_then_settle();
    chk("R6 load one", fb, 1'b1);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R10 async clear", fb, 1'b0);
    edge_then_settle();
    chk("R10 stays clear", fb, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    edge_then_settle();
    chk("R10 midrun edge 1", fb, 1'b0);
    edge_then_settle();
    chk("R10 midrun edge 2", fb, 1'b0);
    edge_then_settle();
    chk("R10 midrun edge 3", fb, 1'b1);
  endtask

  bit done = 1'b0;

  initial begin
    rst_n   = 1'b0;
    cfg     = '0;
    in_bits = '0;
    pin_in  = 1'b0;
    repeat (2) @(negedge clk);
    t_power_up();
    t_comb();
    t_degenerate();
    t_comb_feedback();
    t_input();
    t_registered();
    t_preset_clear();
    t_reset_midrun();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

endmodule